// File: doc/BRIEF.md
# Paired-Operand Dataflow Execute Pipeline

This block is a four-stage in-order execution pipeline for non-blocking dataflow threads: instruction fetch, operand fetch, execute and write-back. A separate unit loads a thread's program and its input operands, then starts the thread. The thread's instructions come from a small program store. A program counter steps through them in order, one per cycle. Nothing waits for data to arrive.

The register file is organised as operand pairs. Every location is addressed by the running thread's context number, a pair offset and a half bit. An instruction names a single pair offset and gets both source operands in one double-width read. Its result does not go to an ordinary destination register. It goes into up to two operand halves that belong to later consumer instructions, and the two writes use two write ports in the same cycle.

Because a thread has no side effects, the only hazard checked is read-after-write. Results still in the execute or write-back stage are forwarded into the operand-fetch stage half by half, so the pipeline never stalls. A halt instruction ends the thread and produces a one-cycle completion pulse that carries the context number.

Top module: `dfx_pipe`

## Requirements
- R1: While the pipeline is not busy, `start` loads `start_ctx` and `start_pc`. Instructions are then fetched from consecutive program addresses, one per cycle. A `start` that arrives while `busy` is high is ignored.
- R2: A register location is addressed as {context, pair offset, half}, with the half bit as the LSB (0 = left operand A, 1 = right operand B). An instruction's source offset reads both halves of one pair of the running context at once.
- R3: The instruction word is {op[2:0], src[OFF_W-1:0], dst0, dst1}. Each dst field is {valid, half, offset[OFF_W-1:0]}. The op codes are 0 A+B, 1 A-B, 2 A&B, 3 A|B, 4 A^B, 5 pass A, 6 pass B, 7 halt.
- R4: The result is written, on a single write-back cycle, to every valid destination of the instruction. Each write appears on its own port (`wb0_*` for dst0, `wb1_*` for dst1), and both ports carry the same `wb_data`. An instruction with no valid destination writes nothing.
- R5: An operand half that an older instruction in the execute or write-back stage is about to write is taken from that instruction's result. Only the matching half is replaced. If both older stages match, the younger instruction's result wins.
- R6: A halt writes nothing, even if its destination fields are valid. When the halt reaches write-back, after every earlier write has completed, `done` pulses for one cycle with `done_ctx` set to the thread's context. `busy` is low in the following cycle.
- R7: Program-store writes (`prog_we`) and operand preload writes (`pl_we`) take effect only while `busy` is low. While busy they are ignored.
- R8: After reset, `busy`, `done`, `wb0_en` and `wb1_en` are low.
- R9: Threads with different context numbers use disjoint register locations, even for equal pair offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | PC_W | Program store write address |
| prog_data | input | IW | Instruction word to store |
| pl_we | input | 1 | Operand preload write enable |
| pl_loc | input | LOC_W | Preload location {context, offset, half} |
| pl_data | input | DATA_W | Preload value |
| start | input | 1 | Start a thread |
| start_ctx | input | CTX_W | Context number of the thread |
| start_pc | input | PC_W | First program address of the thread |
| busy | output | 1 | A thread is running or draining |
| wb0_en | output | 1 | First write port active |
| wb0_loc | output | LOC_W | First write port location |
| wb1_en | output | 1 | Second write port active |
| wb1_loc | output | LOC_W | Second write port location |
| wb_data | output | DATA_W | Value written by both ports |
| done | output | 1 | One-cycle thread completion pulse |
| done_ctx | output | CTX_W | Context of the completed thread |

## Verification
The bench builds the block with its defaults: four contexts, eight pairs per context, 16-bit data and a 32-entry program store. These values let it run threads in two contexts with the same pair offsets and place three separate programs at distinct addresses. They also let it exercise dependency distances of one, two and five instructions, a double write into both halves of one pair, and two writes to the same half followed by a read that must pick the younger value. The bench also pokes the store, the preload port and `start` mid-thread, and the write-back stream shows that all three were ignored.

// File: rtl/dfx_pipe.sv
module dfx_pipe #(
  parameter int CTX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int DATA_W = 16,
  parameter int PC_W   = 5,
  localparam int DW    = OFF_W + 2,
  localparam int IW    = 3 + OFF_W + 2 * DW,
  localparam int LOC_W = CTX_W + OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [PC_W-1:0]   prog_addr,
  input  logic [IW-1:0]     prog_data,
  input  logic              pl_we,
  input  logic [LOC_W-1:0]  pl_loc,
  input  logic [DATA_W-1:0] pl_data,
  input  logic              start,
  input  logic [CTX_W-1:0]  start_ctx,
  input  logic [PC_W-1:0]   start_pc,
  output logic              busy,
  output logic              wb0_en,
  output logic [LOC_W-1:0]  wb0_loc,
  output logic              wb1_en,
  output logic [LOC_W-1:0]  wb1_loc,
  output logic [DATA_W-1:0] wb_data,
  output logic              done,
  output logic [CTX_W-1:0]  done_ctx
);
  localparam int NLOC  = 1 << LOC_W;
  localparam int NPROG = 1 << PC_W;
  localparam logic [2:0] OP_HALT = 3'd7;

  logic [IW-1:0]     imem [NPROG];
  logic [DATA_W-1:0] rf   [NLOC];

  logic              running;
  logic [PC_W-1:0]   pc;
  logic [CTX_W-1:0]  ctx;
  logic              d_v, e_v, w_v, w_halt;
  logic [IW-1:0]     d_ins;
  logic [2:0]        e_op;
  logic [DW-1:0]     e_d0, e_d1, w_d0, w_d1;
  logic [DATA_W-1:0] e_a, e_b, e_res, w_res, fa, fb;

  wire [2:0]       d_op   = d_ins[IW-1 -: 3];
  wire [OFF_W-1:0] d_src  = d_ins[IW-4 -: OFF_W];
  wire             d_halt = d_v && d_op == OP_HALT;
  wire             e_live = e_v && e_op != OP_HALT;
  wire             w_live = w_v && !w_halt;

  assign busy     = running | d_v | e_v | w_v;
  assign wb0_en   = w_live && w_d0[DW-1];
  assign wb1_en   = w_live && w_d1[DW-1];
  assign wb0_loc  = {ctx, w_d0[OFF_W-1:0], w_d0[DW-2]};
  assign wb1_loc  = {ctx, w_d1[OFF_W-1:0], w_d1[DW-2]};
  assign wb_data  = w_res;
  assign done     = w_v && w_halt;
  assign done_ctx = ctx;

  function automatic logic hit(logic [DW-1:0] f, logic h, logic [OFF_W-1:0] o);
    return f[DW-1] && f[DW-2] == h && f[OFF_W-1:0] == o;
  endfunction

  always_comb begin
    fa = rf[{ctx, d_src, 1'b0}];
    fb = rf[{ctx, d_src, 1'b1}];
    if (w_live) begin
      if (hit(w_d0, 1'b0, d_src) || hit(w_d1, 1'b0, d_src)) fa = w_res;
      if (hit(w_d0, 1'b1, d_src) || hit(w_d1, 1'b1, d_src)) fb = w_res;
    end
    if (e_live) begin
      if (hit(e_d0, 1'b0, d_src) || hit(e_d1, 1'b0, d_src)) fa = e_res;
      if (hit(e_d0, 1'b1, d_src) || hit(e_d1, 1'b1, d_src)) fb = e_res;
    end
  end

  always_comb begin
    case (e_op)
      3'd0:    e_res = e_a + e_b;
      3'd1:    e_res = e_a - e_b;
      3'd2:    e_res = e_a & e_b;
      3'd3:    e_res = e_a | e_b;
      3'd4:    e_res = e_a ^ e_b;
      3'd5:    e_res = e_a;
      3'd6:    e_res = e_b;
      default: e_res = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pc      <= '0;
      ctx     <= '0;
      d_v     <= 1'b0;
      e_v     <= 1'b0;
      w_v     <= 1'b0;
    end else begin
      if (start && !busy) begin
        running <= 1'b1;
        pc      <= start_pc;
        ctx     <= start_ctx;
      end else if (d_halt) begin
        running <= 1'b0;
      end
      d_v <= running && !d_halt;
      if (running && !d_halt) pc <= pc + 1'b1;
      e_v <= d_v;
      w_v <= e_v;
    end
  end

  always_ff @(posedge clk) begin
    if (running) d_ins <= imem[pc];
    e_op   <= d_op;
    e_d0   <= d_ins[2*DW-1 -: DW];
    e_d1   <= d_ins[DW-1:0];
    e_a    <= fa;
    e_b    <= fb;
    w_halt <= e_op == OP_HALT;
    w_d0   <= e_d0;
    w_d1   <= e_d1;
    w_res  <= e_res;
  end

  always_ff @(posedge clk) begin
    if (prog_we && !busy) imem[prog_addr] <= prog_data;
    if (pl_we && !busy) rf[pl_loc] <= pl_data;
    if (wb0_en) rf[wb0_loc] <= w_res;
    if (wb1_en) rf[wb1_loc] <= w_res;
  end
endmodule

module dfx_pipe_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic wb0_en,
  input logic wb1_en,
  input logic done
);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_halt_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n) done |-> !(wb0_en || wb1_en));
  p_idle_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  p_write_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n) (wb0_en || wb1_en) |-> busy);
  p_busy_from_start_r1: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
endmodule

bind dfx_pipe dfx_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .wb0_en(wb0_en), .wb1_en(wb1_en), .done(done)
);

// File: tb/tb_dfx_pipe.sv
module tb_dfx_pipe;
  localparam int CTX_W = 2, OFF_W = 3, DATA_W = 16, PC_W = 5;
  localparam int DW = OFF_W + 2, IW = 3 + OFF_W + 2 * DW, LOC_W = CTX_W + OFF_W + 1;
  localparam int EW = 3 + 2 * LOC_W + DATA_W;

  logic clk = 0, rst_n = 0;
  logic prog_we = 0, pl_we = 0, start = 0;
  logic [PC_W-1:0] prog_addr = '0, start_pc = '0;
  logic [IW-1:0] prog_data = '0;
  logic [LOC_W-1:0] pl_loc = '0;
  logic [DATA_W-1:0] pl_data = '0;
  logic [CTX_W-1:0] start_ctx = '0;
  logic busy, wb0_en, wb1_en, done;
  logic [LOC_W-1:0] wb0_loc, wb1_loc;
  logic [DATA_W-1:0] wb_data;
  logic [CTX_W-1:0] done_ctx;

  dfx_pipe dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0, dones = 0;
  bit finished = 0;
  logic [EW-1:0] expq[$];
  logic [IW-1:0] m_prog [1 << PC_W];
  logic [DATA_W-1:0] m_rf [1 << LOC_W];

  function automatic logic [IW-1:0] enc(int op, int src, int v0, int h0, int o0, int v1, int h1, int o1);
    return {op[2:0], src[OFF_W-1:0], v0[0], h0[0], o0[OFF_W-1:0], v1[0], h1[0], o1[OFF_W-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] alu(logic [2:0] op, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a;
      3'd6: return b;
      default: return '0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [EW-1:0] act, logic [EW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int addr, logic [IW-1:0] ins);
    @(negedge clk);
    prog_we = 1; prog_addr = addr[PC_W-1:0]; prog_data = ins;
    m_prog[addr] = ins;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic preload(int c, int off, int h, int val);
    logic [LOC_W-1:0] l;
    l = {c[CTX_W-1:0], off[OFF_W-1:0], h[0]};
    @(negedge clk);
    pl_we = 1; pl_loc = l; pl_data = val[DATA_W-1:0];
    m_rf[l] = val[DATA_W-1:0];
    @(negedge clk);
    pl_we = 0;
  endtask

  // reference: sequential in-order execution of one thread
  task automatic model(int c, int pc0);
    int pc = pc0;
    for (int n = 0; n < 64; n++) begin
      logic [IW-1:0] ins = m_prog[pc];
      logic [2:0] op = ins[IW-1 -: 3];
      logic [OFF_W-1:0] s = ins[IW-4 -: OFF_W];
      logic [DW-1:0] f0 = ins[2*DW-1 -: DW], f1 = ins[DW-1:0];
      logic [LOC_W-1:0] l0, l1;
      logic [DATA_W-1:0] r;
      if (op == 3'd7) begin
        expq.push_back({1'b1, 1'b0, {LOC_W{1'b0}}, 1'b0, {LOC_W{1'b0}}, {(DATA_W-CTX_W){1'b0}}, c[CTX_W-1:0]});
        break;
      end
      r  = alu(op, m_rf[{c[CTX_W-1:0], s, 1'b0}], m_rf[{c[CTX_W-1:0], s, 1'b1}]);
      l0 = {c[CTX_W-1:0], f0[OFF_W-1:0], f0[DW-2]};
      l1 = {c[CTX_W-1:0], f1[OFF_W-1:0], f1[DW-2]};
      if (f0[DW-1] || f1[DW-1])
        expq.push_back({1'b0, f0[DW-1], f0[DW-1] ? l0 : {LOC_W{1'b0}},
                        f1[DW-1], f1[DW-1] ? l1 : {LOC_W{1'b0}}, r});
      if (f0[DW-1]) m_rf[l0] = r;
      if (f1[DW-1]) m_rf[l1] = r;
      pc = (pc + 1) % (1 << PC_W);
    end
  endtask

  task automatic launch(int c, int pc0);
    model(c, pc0);
    @(negedge clk);
    start = 1; start_ctx = c[CTX_W-1:0]; start_pc = pc0[PC_W-1:0];
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(int target);
    while (dones < target) @(negedge clk);
    @(negedge clk);
    check(!busy, "R6 idle after done", {{(EW-1){1'b0}}, busy}, '0);
  endtask

  // monitor: R4 R5 R6 write-back and completion stream against the scoreboard
  always @(negedge clk) begin
    if (rst_n && (done || wb0_en || wb1_en)) begin
      logic [EW-1:0] obs, exp;
      obs = {done, wb0_en, wb0_en ? wb0_loc : {LOC_W{1'b0}}, wb1_en, wb1_en ? wb1_loc : {LOC_W{1'b0}},
             done ? {{(DATA_W-CTX_W){1'b0}}, done_ctx} : wb_data};
      if (expq.size() == 0) check(0, "R4 unexpected write-back", obs, '0);
      else begin
        exp = expq.pop_front();
        check(obs == exp, exp[EW-1] ? "R6 done pulse" : "R4/R5 write-back", obs, exp);
      end
      if (done) dones++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=50000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check({busy, done, wb0_en, wb1_en} == 4'b0, "R8 reset outputs", {busy, done, wb0_en, wb1_en}, '0);
    rst_n = 1;
    for (int i = 0; i < (1 << LOC_W); i++) preload(i >> (OFF_W + 1), (i >> 1) % (1 << OFF_W), i % 2, 0);
    for (int i = 0; i < (1 << PC_W); i++) load(i, enc(7, 0, 0, 0, 0, 0, 0, 0));

    // thread 1, context 1: R2 R3 R5 forwarding distances, both halves, younger wins
    preload(1, 0, 0, 5); preload(1, 0, 1, 3);
    preload(1, 1, 0, 10); preload(1, 1, 1, 4);
    load(0, enc(0, 0, 1, 0, 2, 1, 1, 3));   // ADD p0 -> p2.A, p3.B
    load(1, enc(1, 1, 1, 1, 2, 0, 0, 0));   // SUB p1 -> p2.B
    load(2, enc(4, 2, 1, 0, 4, 0, 0, 0));   // XOR p2 (A via W, B via E) -> p4.A
    load(3, enc(5, 4, 1, 0, 5, 1, 1, 5));   // PASSA -> both halves of p5
    load(4, enc(2, 5, 0, 0, 0, 1, 0, 6));   // AND p5 -> p6.A (dst1 only)
    load(5, enc(0, 3, 1, 0, 7, 0, 0, 0));   // ADD p3 (B from register file) -> p7.A
    load(6, enc(5, 0, 1, 1, 6, 0, 0, 0));   // PASSA p0 -> p6.B
    load(7, enc(6, 0, 1, 1, 6, 0, 0, 0));   // PASSB p0 -> p6.B (younger)
    load(8, enc(3, 6, 1, 1, 7, 0, 0, 0));   // OR p6 -> p7.B, must see 3
    load(9, enc(0, 7, 0, 0, 0, 0, 0, 0));   // R4 no valid destination: no write
    load(10, enc(7, 7, 1, 0, 1, 1, 1, 1));  // R6 halt with valid dst fields
    launch(1, 0);
    wait_done(1);

    // thread 2, context 2: R9 same offsets, R7 and R1 ignored pokes while busy
    preload(2, 0, 0, 100); preload(2, 0, 1, 1);
    load(16, enc(1, 0, 1, 0, 1, 0, 0, 0));
    load(17, enc(5, 1, 1, 1, 1, 0, 0, 0));
    load(18, enc(6, 0, 1, 0, 2, 0, 0, 0));
    load(19, enc(0, 1, 1, 1, 2, 0, 0, 0));
    load(20, enc(7, 0, 0, 0, 0, 0, 0, 0));
    launch(2, 16);
    pl_we = 1; pl_loc = {2'd2, 3'd0, 1'b1}; pl_data = 16'hBEEF;
    prog_we = 1; prog_addr = 5'd19; prog_data = enc(2, 0, 1, 0, 4, 0, 0, 0);
    start = 1; start_ctx = 2'd3; start_pc = 5'd0;
    @(negedge clk);
    pl_we = 0; prog_we = 0; start = 0;
    wait_done(2);

    // thread 3, context 1 again: R9 context 1 pair 0 untouched by context 2
    load(24, enc(6, 0, 0, 0, 0, 1, 0, 3));
    load(25, enc(0, 0, 1, 1, 4, 0, 0, 0));
    load(26, enc(7, 0, 0, 0, 0, 0, 0, 0));
    launch(1, 24);
    wait_done(3);

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R4 all expected writes seen", expq.size(), '0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule